// File: doc/BRIEF.md
# Narrow-Operand Gated Integer ALU

This block is a 64-bit integer ALU that saves switching power on operations whose operands are small. Each operand is held in two registers: a 16-bit low slice and a 48-bit high slice. When both incoming operands are sign extensions of their bit 15, only the low slices load. The high slices keep their old contents, so the upper part of the datapath stays quiet. The operation then runs on a 16-bit path. The upper 48 result bits are rebuilt by copying result bit 15.

If the 16-bit result of a narrow operation cannot represent the true value, the block stalls for one cycle. During that cycle it fills the high slices by sign extension and runs the operation again on the full-width path. An issuing stage presents an operation with `in_valid`, holds it while `busy` is high, and takes each result when `out_valid` is high. The `narrow_used` flag tells which path produced the result.

Top module: `narrow_gated_alu`

## Requirements
- R1: An operand is narrow exactly when its bits 63..15 are all equal. For example, 0xFFFF_FFFF_FFFF_8000 is narrow, and 0x0000_0000_0000_8000 is wide.
- R2: `narrow_used` is 1 with a result only if both operands were narrow and the 16-bit result fits (R9). In every other case it is 0.
- R3: When an accepted operation has two narrow operands, the 48-bit upper operand registers keep their previous contents in the following cycle.
- R4: When `narrow_used` is 1, result bits 63..16 are copies of result bit 15.
- R5: A narrow operation that does not fit drives `busy` high for one cycle. Its full-width result appears one cycle later with `narrow_used` 0. An `in_valid` presented while `busy` is high is ignored.
- R6: Opcode encodings:
  - 0: add
  - 1: subtract (a-b)
  - 2: multiply (low 64 bits)
  - 3: AND
  - 4: OR
  - 5: XOR
  - 6: shift a left by b[5:0]
  - 7: arithmetic shift a right by b[5:0]
- R7: An operation accepted at a clock edge (`in_valid` high, `busy` low) produces exactly one `out_valid` pulse. The pulse comes in the cycle after that edge, or one cycle later when R5 applies. There is no `out_valid` without an accepted operation.
- R8: After reset, `out_valid` and `busy` are 0.
- R9: Fit rules on the narrow path:
  - Add, subtract and multiply fit when the exact result lies in the signed 16-bit range.
  - The bitwise operations and the right shift always fit.
  - The left shift fits when operand a is zero, or when the shift amount is below 16 and the result lies in the signed 16-bit range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An operation is presented |
| opcode | input | 3 | Operation code (R6) |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand; bits 5..0 are the shift amount |
| busy | output | 1 | Replay cycle in progress; input is not taken |
| out_valid | output | 1 | Result is valid this cycle |
| narrow_used | output | 1 | Result came from the 16-bit path |
| result | output | 64 | Operation result |

## Verification
A result is due one cycle after the clock edge that accepted its operation, or two cycles after it when the narrow result did not fit. The bench records the cycle number at acceptance and adds one or two according to its own fit calculation. On each falling edge it checks that `out_valid` rises in exactly that cycle, in order. While `busy` is high, the bench holds junk operands on the inputs, and the model expects no output from them.

// File: rtl/narrow_gated_alu.sv
module narrow_gated_alu #(
  parameter int DW = 64,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [2:0]    opcode,
  input  logic [DW-1:0] op_a,
  input  logic [DW-1:0] op_b,
  output logic          busy,
  output logic          out_valid,
  output logic          narrow_used,
  output logic [DW-1:0] result
);
  localparam int HW  = DW - LW;
  localparam int PW  = 2 * LW;
  localparam int SW  = $clog2(DW);
  localparam int LSW = $clog2(LW);

  function automatic logic is_narrow(input logic [DW-1:0] x);
    return (x[DW-1:LW-1] == '0) || (&x[DW-1:LW-1]);
  endfunction

  function automatic logic fits(input logic [PW-1:0] x);
    return (x[PW-1:LW-1] == '0) || (&x[PW-1:LW-1]);
  endfunction

  logic [HW-1:0] a_hi, b_hi;
  logic [LW-1:0] a_lo, b_lo;
  logic [2:0]    op_q;
  logic          vld_q, nar_q, nfit;
  logic [DW-1:0] wres;
  logic [PW-1:0] nr;

  wire           accept = in_valid & ~busy;
  wire           nar_in = is_narrow(op_a) & is_narrow(op_b);
  wire [DW-1:0]  wa     = {a_hi, a_lo};
  wire [DW-1:0]  wb     = {b_hi, b_lo};
  wire [PW-1:0]  sa     = {{LW{a_lo[LW-1]}}, a_lo};
  wire [PW-1:0]  sb     = {{LW{b_lo[LW-1]}}, b_lo};
  wire [SW-1:0]  shamt  = b_lo[SW-1:0];

  assign busy        = vld_q & nar_q & ~nfit;
  assign out_valid   = vld_q & ~busy;
  assign narrow_used = nar_q;
  assign result      = nar_q ? {{HW{nr[LW-1]}}, nr[LW-1:0]} : wres;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      nar_q <= 1'b0;
      op_q  <= '0;
      a_lo  <= '0;
      b_lo  <= '0;
      a_hi  <= '0;
      b_hi  <= '0;
    end else if (busy) begin
      a_hi  <= {HW{a_lo[LW-1]}};
      b_hi  <= {HW{b_lo[LW-1]}};
      nar_q <= 1'b0;
      vld_q <= 1'b1;
    end else begin
      vld_q <= accept;
      if (accept) begin
        a_lo  <= op_a[LW-1:0];
        b_lo  <= op_b[LW-1:0];
        op_q  <= opcode;
        nar_q <= nar_in;
        if (!nar_in) begin
          a_hi <= op_a[DW-1:LW];
          b_hi <= op_b[DW-1:LW];
        end
      end
    end
  end

  always_comb begin
    case (op_q)
      3'd0:    wres = wa + wb;
      3'd1:    wres = wa - wb;
      3'd2:    wres = wa * wb;
      3'd3:    wres = wa & wb;
      3'd4:    wres = wa | wb;
      3'd5:    wres = wa ^ wb;
      3'd6:    wres = wa << shamt;
      default: wres = $signed(wa) >>> shamt;
    endcase
  end

  always_comb begin
    nfit = 1'b1;
    case (op_q)
      3'd0:    begin nr = sa + sb; nfit = fits(nr); end
      3'd1:    begin nr = sa - sb; nfit = fits(nr); end
      3'd2:    begin nr = sa * sb; nfit = fits(nr); end
      3'd3:    nr = sa & sb;
      3'd4:    nr = sa | sb;
      3'd5:    nr = sa ^ sb;
      3'd6:    begin
                 nr   = sa << shamt[LSW-1:0];
                 nfit = (a_lo == '0) || ((shamt < SW'(LW)) && fits(nr));
               end
      default: nr = $signed(sa) >>> shamt;
    endcase
  end
endmodule

module narrow_gated_alu_chk #(
  parameter int DW = 64,
  parameter int LW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] op_a,
  input logic [DW-1:0] op_b,
  input logic          busy,
  input logic          out_valid,
  input logic          narrow_used,
  input logic [DW-1:0] result,
  input logic [DW-LW-1:0] a_hi,
  input logic [DW-LW-1:0] b_hi
);
  wire both_nar = ((op_a[DW-1:LW-1] == '0) || (&op_a[DW-1:LW-1])) &&
                  ((op_b[DW-1:LW-1] == '0) || (&op_b[DW-1:LW-1]));

  p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy && both_nar) |=> ($stable(a_hi) && $stable(b_hi)));

  p_fill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && narrow_used) |->
      ($countones(result[DW-1:LW-1]) == 0 || $countones(result[DW-1:LW-1]) == DW-LW+1));

  p_replay_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (out_valid && !narrow_used && !busy));

  p_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !busy) |=> (out_valid || busy));

  p_no_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_valid && !busy) && !busy) |=> !out_valid);

  p_busy_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && out_valid));
endmodule

bind narrow_gated_alu narrow_gated_alu_chk #(.DW(DW), .LW(LW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .busy(busy), .out_valid(out_valid), .narrow_used(narrow_used),
  .result(result), .a_hi(a_hi), .b_hi(b_hi)
);

// File: tb/narrow_gated_alu_tb.sv
module narrow_gated_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  opcode = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic        busy, out_valid, narrow_used;
  logic [63:0] result;

  narrow_gated_alu dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .op_a(op_a), .op_b(op_b), .busy(busy), .out_valid(out_valid),
    .narrow_used(narrow_used), .result(result)
  );

  always #10 clk = ~clk;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 1'b0;
  logic [63:0] q_res[$];
  bit          q_nar[$];
  int          q_due[$];
  string       q_tag[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic bit nar(input logic [63:0] x);
    return (x[63:15] == '0) || (&x[63:15]);
  endfunction

  function automatic logic [63:0] model(input logic [2:0] op, input logic [63:0] a, input logic [63:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a * b;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return a ^ b;
      3'd6: return a << b[5:0];
      default: return $signed(a) >>> b[5:0];
    endcase
  endfunction

  // R9 fit rule, taken from the requirement
  function automatic bit fit(input logic [2:0] op, input logic [63:0] a, input logic [63:0] r, input logic [63:0] b);
    if (op == 3'd6) return (a == '0) || ((b[5:0] < 16) && nar(r));
    return nar(r);
  endfunction

  task automatic issue(input logic [63:0] a, input logic [63:0] b, input logic [2:0] op, input string tag);
    logic [63:0] r;
    bit nu;
    @(negedge clk);
    while (busy) begin
      in_valid = 1'b1; op_a = 64'hDEAD_BEEF_0BAD_F00D; op_b = 64'h3; opcode = 3'd0;
      @(negedge clk);
    end
    in_valid = 1'b1; op_a = a; op_b = b; opcode = op;
    r  = model(op, a, b);
    nu = nar(a) && nar(b) && fit(op, a, r, b);
    q_res.push_back(r);
    q_nar.push_back(nu);
    q_tag.push_back(tag);
    q_due.push_back(cyc + 1 + ((nar(a) && nar(b) && !nu) ? 1 : 0));
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (out_valid) begin
        if (q_res.size() == 0) chk(1'b0, "R7 unexpected out_valid", result, 64'h0);
        else begin
          chk(result == q_res[0], {q_tag[0], " R6 result"}, result, q_res[0]);
          chk(narrow_used == q_nar[0], {q_tag[0], " R2 narrow_used"}, 64'(narrow_used), 64'(q_nar[0]));
          chk(cyc == q_due[0], {q_tag[0], " R7 latency"}, 64'(cyc), 64'(q_due[0]));
          if (narrow_used)
            chk(nar(result), {q_tag[0], " R4 upper fill"}, result, {{48{result[15]}}, result[15:0]});
          void'(q_res.pop_front()); void'(q_nar.pop_front());
          void'(q_due.pop_front()); void'(q_tag.pop_front());
        end
      end else if (q_due.size() > 0 && q_due[0] < cyc) begin
        chk(1'b0, {q_tag[0], " R7 missing result"}, 64'(cyc), 64'(q_due[0]));
        void'(q_res.pop_front()); void'(q_nar.pop_front());
        void'(q_due.pop_front()); void'(q_tag.pop_front());
      end
    end
  end

  function automatic logic [63:0] rnd(input bit narrow);
    logic [63:0] v = {$urandom, $urandom};
    return narrow ? {{48{v[15]}}, v[15:0]} : v;
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 64'(cyc), 64'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !busy, "R8 reset state", {62'h0, out_valid, busy}, 64'h0);

    issue(64'd5, 64'd7, 3'd0, "R2 narrow add");
    issue(64'h7FFF, 64'd1, 3'd0, "R5 add overflow");
    issue(64'd3, 64'd10, 3'd1, "R9 narrow sub");
    issue(64'hFFFF_FFFF_FFFF_8000, 64'hFFFF_FFFF_FFFF_8000, 3'd1, "R1 all-ones upper");
    issue(64'h0000_0000_0000_8000, 64'd1, 3'd0, "R1 bit15 wide");
    issue(64'd100, -64'sd3, 3'd2, "R9 mul fits");
    issue(64'd300, 64'd300, 3'd2, "R5 mul overflow");
    issue(64'h1234, 64'hFFFF_FFFF_FFFF_F0F0, 3'd3, "R6 and");
    issue(64'h1234, 64'h00F0, 3'd4, "R6 or");
    issue(64'h1234, 64'h7777, 3'd5, "R6 xor");
    issue(64'd3, 64'd4, 3'd6, "R9 sll fits");
    issue(64'd0, 64'd40, 3'd6, "R9 sll zero operand");
    issue(64'd1, 64'd20, 3'd6, "R9 sll far");
    issue(-64'sd200, 64'd3, 3'd7, "R6 sra");
    issue(64'h1_0000_0000, 64'd5, 3'd0, "R2 one wide");
    issue(64'hAAAA_5555_0000_1111, 64'h1111_2222_3333_4444, 3'd2, "R6 wide mul");
    issue(64'hFFFF_0000_0000_0001, 64'd5, 3'd0, "R3 wide after narrow");
    issue(64'd2, 64'd2, 3'd0, "R3 narrow");
    issue(64'h0F0F_0000_0000_0000, 64'd1, 3'd1, "R3 wide reloads upper");
    issue(64'h4000, 64'h4000, 3'd0, "R5 replay then ignore");
    issue(64'd9, 64'd9, 3'd2, "R5 after replay");

    for (int i = 0; i < 400; i++) begin
      logic [63:0] a, b;
      a = rnd(($urandom % 4) != 0);
      b = rnd(($urandom % 4) != 0);
      issue(a, b, 3'($urandom % 8), "R6 random");
      if (($urandom % 5) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
      end
    end

    @(negedge clk);
    in_valid = 1'b0;
    repeat (5) @(negedge clk);
    chk(q_res.size() == 0, "R7 all results delivered", 64'(q_res.size()), 64'h0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule